// File: doc/BRIEF.md
# Histogram Equalization Table Builder and Pixel Remapper

This block runs one frame of histogram equalization from the controller's side. A start request clears an external bank of cumulative level counters. The block then passes every pixel of the next frame to that bank as an increment request and counts them. When the frame is complete it walks through every gray level. For each level it selects that level's counter and stores the counter's upper byte in an internal look-up table. The stored byte is the cumulative count divided by 256.

After the table is built, the block signals completion and switches to remapping. Every pixel that arrives on the input stream is looked up in the table, and the equalized value leaves on the output stream one cycle later. A new start request takes the block out of remapping and begins the next frame. The counter bank and any image storage sit outside this block.

Both pixel streams use valid/ready handshakes. An input pixel is taken in any cycle where `s_valid` and `s_ready` are both high. An output pixel is delivered in any cycle where `m_valid` and `m_ready` are both high. During accumulation the block never stalls the input. During remapping it holds one result. While that result is waiting and `m_ready` is low, `s_ready` is low and the result stays unchanged. In the same cycle that `m_ready` rises, `s_ready` may rise too, so a new pixel is taken while the held one leaves. Outside these two phases `s_ready` is low. Once `m_valid` rises it stays high until the result is taken.

Top module: `heq_table_remap`

## Requirements
- R1: After reset, `done`, `s_ready`, `m_valid`, `bank_clr` and `bank_inc_en` are all low.
- R2: A `start` seen while idle, while done or while remapping raises `bank_clr` in that same cycle only. During the accumulation phase that follows, `s_ready` is high, and each pixel taken raises `bank_inc_en` in the same cycle, with `bank_inc_level` equal to that pixel.
- R3: Accumulation ends after exactly `FRAME_PIXELS` pixels have been taken (65536 by default). From the next cycle `s_ready` is low and no increment is issued, even while `s_valid` stays high.
- R4: The build phase lasts exactly 256 consecutive cycles. In the n-th of these cycles `cnt_sel` equals n, for n = 0 to 255, and the table entry for level n is written from `cnt_rdata`.
- R5: `cnt_rdata` is a 17-bit count. While bit 16 is clear, the entry written is bits [15:8] of the count, which is the count divided by 256 with the remainder dropped.
- R6: If bit 16 of `cnt_rdata` is set (a count of 65536), the entry is 255. A saturated count of 0xFFFF also gives 255.
- R7: `done` is high for exactly one cycle, the cycle right after the last build cycle. Remapping starts in the cycle after that.
- R8: A `start` during accumulation or build is ignored. It raises no `bank_clr`, and the pixel count and the build length are unchanged.
- R9: In remapping, a pixel p taken at a clock edge gives `m_valid` high with `m_pixel` equal to table entry p in the next cycle.
- R10: While `m_valid` is high and `m_ready` is low, `s_ready` is low in remapping, and `m_valid` and `m_pixel` hold their values.
- R11: If `start` arrives in the same cycle as a remap handshake, that pixel is still mapped through the old table and delivered. Pixels taken after that cycle are accumulation increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a new frame |
| done | output | 1 | One-cycle pulse when the table is complete |
| bank_clr | output | 1 | Clears the external counter bank |
| bank_inc_en | output | 1 | Increment request to the counter bank |
| bank_inc_level | output | 8 | Gray level to increment |
| cnt_sel | output | 8 | Counter selected for reading during build |
| cnt_rdata | input | 17 | Cumulative count of the selected counter |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel ready |
| s_pixel | input | 8 | Input pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel ready |
| m_pixel | output | 8 | Equalized output pixel |

## Verification
The two functions that can fall in the same cycle are a start request and a remap handshake. To provoke this, the bench raises `start` in the very cycle that a remap pixel is offered, while the output is ready. It then judges two things. The result that appears next must come from the old table. Only pixels taken after that cycle may appear as increments toward the counter bank. A second kind of overlap is a start request that lands in the middle of accumulation or build. This case is judged by an unchanged pixel count, an unchanged build length and a missing clear pulse.

// File: rtl/heq_pkg.sv
package heq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_BUILD,
    ST_READY,
    ST_REMAP
  } heq_state_e;
endpackage

// File: rtl/heq_entry_calc.sv
// Converts a cumulative count into a table entry: upper byte, or all ones on overflow.
module heq_entry_calc #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic [CNT_W:0]   cnt,
  output logic [PIX_W-1:0] entry
);
  always_comb begin
    if (cnt[CNT_W]) entry = '1;
    else            entry = cnt[CNT_W-1 -: PIX_W];
  end
endmodule

// File: rtl/heq_lut_ram.sv
// Simple dual-port table: one write port, one registered read port.
module heq_lut_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/heq_seq.sv
// Frame sequencer: idle, accumulate, build, ready, remap.
module heq_seq
  import heq_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int FRAME_PIXELS = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             acc_fire,
  output heq_state_e       state,
  output logic [PIX_W-1:0] idx,
  output logic             clr,
  output logic             wr_en
);
  localparam int PCW = (FRAME_PIXELS > 1) ? $clog2(FRAME_PIXELS) : 1;
  localparam logic [PCW-1:0] LAST_PIX = PCW'(FRAME_PIXELS - 1);

  logic [PCW-1:0] pix_cnt;
  logic           start_ok;

  always_comb begin
    start_ok = start && (state == ST_IDLE || state == ST_READY || state == ST_REMAP);
    clr      = start_ok;
    wr_en    = (state == ST_BUILD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      pix_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_REMAP: begin
          if (start_ok) begin
            state   <= ST_ACC;
            pix_cnt <= '0;
          end
        end
        ST_READY: begin
          if (start_ok) begin
            state   <= ST_ACC;
            pix_cnt <= '0;
          end else begin
            state <= ST_REMAP;
          end
        end
        ST_ACC: begin
          if (acc_fire) begin
            if (pix_cnt == LAST_PIX) begin
              state   <= ST_BUILD;
              idx     <= '0;
              pix_cnt <= '0;
            end else begin
              pix_cnt <= pix_cnt + 1'b1;
            end
          end
        end
        ST_BUILD: begin
          if (idx == '1) begin
            state <= ST_READY;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/heq_table_remap.sv
module heq_table_remap
  import heq_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int CNT_W        = 16,
  parameter int FRAME_PIXELS = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             bank_clr,
  output logic             bank_inc_en,
  output logic [PIX_W-1:0] bank_inc_level,
  output logic [PIX_W-1:0] cnt_sel,
  input  logic [CNT_W:0]   cnt_rdata,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_pixel,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_pixel
);
  heq_state_e       st;
  logic [PIX_W-1:0] idx;
  logic             wr_en;
  logic [PIX_W-1:0] wr_data;
  logic             clr;
  logic             acc_fire;
  logic             remap_fire;
  logic             m_valid_q;
  logic [PIX_W-1:0] rd_q;

  heq_seq #(.PIX_W(PIX_W), .FRAME_PIXELS(FRAME_PIXELS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .acc_fire (acc_fire),
    .state    (st),
    .idx      (idx),
    .clr      (clr),
    .wr_en    (wr_en)
  );

  heq_entry_calc #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_calc (
    .cnt   (cnt_rdata),
    .entry (wr_data)
  );

  heq_lut_ram #(.AW(PIX_W), .DW(PIX_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (idx),
    .wdata (wr_data),
    .re    (remap_fire),
    .raddr (s_pixel),
    .rdata (rd_q)
  );

  always_comb begin
    s_ready        = (st == ST_ACC) || ((st == ST_REMAP) && (!m_valid_q || m_ready));
    acc_fire       = (st == ST_ACC) && s_valid;
    remap_fire     = (st == ST_REMAP) && s_valid && s_ready;
    bank_inc_en    = acc_fire;
    bank_inc_level = s_pixel;
    bank_clr       = clr;
    cnt_sel        = idx;
    done           = (st == ST_READY);
    m_valid        = m_valid_q;
    m_pixel        = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          m_valid_q <= 1'b0;
    else if (remap_fire) m_valid_q <= 1'b1;
    else if (m_ready)    m_valid_q <= 1'b0;
  end
endmodule

// File: rtl/heq_table_remap_chk.sv
module heq_table_remap_chk
  import heq_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             bank_clr,
  input logic             bank_inc_en,
  input logic [PIX_W-1:0] cnt_sel,
  input logic [CNT_W:0]   cnt_rdata,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_pixel,
  input heq_state_e       st,
  input logic             wr_en,
  input logic [PIX_W-1:0] wr_data
);
  p_clr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_clr |=> !bank_clr);

  p_inc_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_inc_en |-> (s_valid && s_ready));

  p_build_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACC) |=> (st != ST_BUILD) || (cnt_sel == '0));

  p_sel_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUILD) |=> (st != ST_BUILD) || (cnt_sel == PIX_W'($past(cnt_sel) + 1)));

  p_overflow_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt_rdata[CNT_W]) |-> (wr_data == '1));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_remap_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_REMAP) && s_valid && s_ready) |=> m_valid);

  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pixel)));

  p_stall_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && (st == ST_REMAP)) |-> !s_ready);
endmodule

bind heq_table_remap heq_table_remap_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .bank_clr    (bank_clr),
  .bank_inc_en (bank_inc_en),
  .cnt_sel     (cnt_sel),
  .cnt_rdata   (cnt_rdata),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_pixel     (m_pixel),
  .st          (st),
  .wr_en       (wr_en),
  .wr_data     (wr_data)
);

// File: tb/heq_table_remap_tb.sv
module heq_table_remap_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       done, bank_clr, bank_inc_en;
  logic [7:0] bank_inc_level, cnt_sel;
  logic [16:0] cnt_rdata;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_pixel = '0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_pixel;

  int errors = 0;
  int checks = 0;
  int mode = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  heq_table_remap #(.PIX_W(8), .CNT_W(16), .FRAME_PIXELS(FRAME)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .bank_clr(bank_clr), .bank_inc_en(bank_inc_en), .bank_inc_level(bank_inc_level),
    .cnt_sel(cnt_sel), .cnt_rdata(cnt_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_pixel(s_pixel),
    .m_valid(m_valid), .m_ready(m_ready), .m_pixel(m_pixel)
  );

  // Stand-in for the counter bank: a chosen count per level.
  function automatic int bank_val(int md, int k);
    if (md == 0) return k * 257;
    if (k >= 250) return 65536;
    if (k == 249) return 65535;
    return k * 131 + 17;
  endfunction

  function automatic int exp_entry(int md, int k);
    int v;
    v = bank_val(md, k);
    if (v >= 65536) return 255;
    return v / 256;
  endfunction

  always_comb cnt_rdata = 17'(bank_val(mode, int'(cnt_sel)));

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!done && !s_ready && !m_valid && !bank_clr && !bank_inc_en, "R1 reset outputs",
        int'({done, s_ready, m_valid, bank_clr, bank_inc_en}), 0);
  endtask

  task automatic t_start();
    @(negedge clk);
    start = 1'b1; #1;
    chk(bank_clr == 1'b1, "R2 clear pulse on start", int'(bank_clr), 1);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; #1;
    chk(bank_clr == 1'b0, "R2 clear lasts one cycle", int'(bank_clr), 0);
    chk(s_ready == 1'b1, "R2 ready in accumulation", int'(s_ready), 1);
  endtask

  // Feed n accumulation pixels; a start is injected midway.
  task automatic feed_acc(int n);
    int incs = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      s_valid = 1'b1;
      s_pixel = 8'(i * 37 + 3);
      start   = (i == 5);
      #1;
      if (bank_inc_en && bank_inc_level == s_pixel) incs++;
      if (i == 5) chk(bank_clr == 1'b0, "R8 start ignored in accumulation", int'(bank_clr), 0);
      @(posedge clk);
    end
    start = 1'b0;
    chk(incs == n, "R2 increment per accepted pixel", incs, n);
  endtask

  // Observe the build phase; s_valid stays high to show nothing is taken.
  task automatic wait_build();
    int n = 0;
    bit sel_ok = 1'b1;
    bit quiet = 1'b1;
    while (n < 300) begin
      @(negedge clk);
      if (n == 101) start = 1'b0;
      #1;
      if (done) break;
      if (n == 0)
        chk(!s_ready && !bank_inc_en, "R3 accumulation closed after frame",
            int'({s_ready, bank_inc_en}), 0);
      if (cnt_sel != 8'(n)) sel_ok = 1'b0;
      if (s_ready || bank_inc_en) quiet = 1'b0;
      if (n == 100) begin
        start = 1'b1; #1;
        chk(bank_clr == 1'b0, "R8 start ignored in build", int'(bank_clr), 0);
      end
      n++;
    end
    start = 1'b0;
    s_valid = 1'b0;
    chk(n == 256, "R4 build length", n, 256);
    chk(sel_ok, "R4 select order", int'(sel_ok), 1);
    chk(quiet, "R3 no input taken during build", int'(quiet), 1);
    chk(done == 1'b1, "R7 done after build", int'(done), 1);
    @(negedge clk); #1;
    chk(done == 1'b0, "R7 done is one cycle", int'(done), 0);
  endtask

  task automatic t_frame(int md);
    mode = md;
    t_start();
    feed_acc(FRAME);
    wait_build();
  endtask

  // Stream levels with the output always ready; check one-cycle latency.
  task automatic t_remap(int md, string req);
    int lv [8] = '{0, 255, 128, 1, 249, 250, 17, 254};
    int prev = -1;
    m_ready = 1'b1;
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk); #1;
      if (prev >= 0)
        chk(m_valid && m_pixel == 8'(exp_entry(md, prev)), req,
            int'(m_pixel), exp_entry(md, prev));
      if (i < 8) begin
        s_valid = 1'b1;
        s_pixel = 8'(lv[i]);
        prev = lv[i];
        #1;
        chk(s_ready == 1'b1, "R9 ready in remap", int'(s_ready), 1);
      end else begin
        s_valid = 1'b0;
      end
    end
  endtask

  task automatic t_backpressure(int md);
    bit held = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    s_valid = 1'b1;
    s_pixel = 8'd200;
    @(negedge clk);
    s_pixel = 8'd60;
    for (int i = 0; i < 3; i++) begin
      #1;
      if (!m_valid || s_ready || m_pixel != 8'(exp_entry(md, 200))) held = 1'b0;
      @(negedge clk);
    end
    chk(held, "R10 stall holds output and blocks input", int'(m_pixel), exp_entry(md, 200));
    m_ready = 1'b1; #1;
    chk(s_ready == 1'b1, "R10 ready follows output ready", int'(s_ready), 1);
    @(negedge clk);
    s_valid = 1'b0; #1;
    chk(m_valid && m_pixel == 8'(exp_entry(md, 60)), "R10 next result after release",
        int'(m_pixel), exp_entry(md, 60));
    @(negedge clk);
  endtask

  // Start and remap handshake in the same cycle, then finish the next frame.
  task automatic t_collide(int old_md, int new_md);
    @(negedge clk);
    m_ready = 1'b1;
    s_valid = 1'b1;
    s_pixel = 8'd249;
    start   = 1'b1; #1;
    chk(s_ready && !bank_inc_en && bank_clr, "R11 remap pixel taken with start",
        int'({s_ready, bank_inc_en, bank_clr}), 5);
    @(negedge clk);
    start = 1'b0;
    mode  = new_md;
    s_pixel = 8'd7; #1;
    chk(m_valid && m_pixel == 8'(exp_entry(old_md, 249)), "R11 old table used",
        int'(m_pixel), exp_entry(old_md, 249));
    chk(bank_inc_en && bank_inc_level == 8'd7, "R11 later pixel accumulates",
        int'(bank_inc_en), 1);
    @(posedge clk);
    @(negedge clk);
    feed_acc(FRAME - 1);
    wait_build();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_frame(0);
    t_remap(0, "R5 remap scaled count");
    t_backpressure(0);
    t_collide(0, 1);
    t_remap(1, "R6 overflow and saturation entries");
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule